// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a relative branch of a small 8-bit CPU is taken and produces the program counter that fetch should use next. It takes the four condition flags, a 4-bit condition code, a flag choosing a short (8-bit) or long (16-bit) signed displacement, the displacement itself, and the address of the instruction after the branch. It returns a taken bit and the next program counter. Both are registered and valid one clock after the inputs are presented.

The condition codes come in pairs. Each odd code is the logical complement of the even code just below it. This lets the evaluator compute one base test from bits [3:1] and invert it with bit 0.

The displacement is always added to the address of the following instruction, never to the address of the branch opcode. The sum wraps modulo 2^16. A branch that is not taken simply continues at the following instruction.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, `taken` becomes 0 and `target_pc` becomes 0.
- R2: The outputs are registered. The values on `taken` and `target_pc` after a rising edge reflect only the inputs sampled at that edge.
- R3: Code 0 is always taken and code 1 is never taken, whatever the flags are. The flag vector `flags` carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R4: Code 2 (unsigned higher) is taken when C and Z are both clear. Code 3 (unsigned lower-or-same) is taken when C or Z is set.
- R5: Code 4 (carry clear, which is also unsigned higher-or-same) is taken when C=0. Code 5 (carry set, which is also unsigned lower) is taken when C=1.
- R6: Code 6 is taken when Z=0 and code 7 when Z=1. Code 8 is taken when V=0 and code 9 when V=1. Code 10 is taken when N=0 and code 11 when N=1.
- R7: The signed codes are evaluated as follows. Code 12 (greater-or-equal) is taken when N equals V. Code 13 (less-than) is taken when N differs from V. Code 14 (greater-than) is taken when Z=0 and N equals V. Code 15 (less-or-equal) is taken when Z=1 or N differs from V.
- R8: A taken branch with `long_sel`=0 gives `next_pc` plus the sign-extended `disp[7:0]`, modulo 2^16. In this case `disp[15:8]` has no effect.
- R9: A taken branch with `long_sel`=1 gives `next_pc` plus the signed 16-bit `disp`, modulo 2^16, so the result can wrap across address 0.
- R10: A branch that is not taken gives `target_pc` equal to `next_pc`, whatever the displacement is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flags | input | 4 | Condition flags {N, Z, V, C} |
| cond_sel | input | 4 | Branch condition code |
| long_sel | input | 1 | 1 selects the 16-bit displacement, 0 the 8-bit one |
| disp | input | 16 | Signed displacement; only bits [7:0] are used for a short branch |
| next_pc | input | 16 | Address of the instruction following the branch |
| taken | output | 1 | Registered branch decision |
| target_pc | output | 16 | Registered next program counter |

## Verification
The hardest cases to reach are the displacement sums that wrap past the top or the bottom of the 64K space. They only show up when a taken branch combines an extreme `next_pc` with a displacement of the right sign.

The stimulus therefore forces the branch taken with code 0. It sweeps all 256 short displacements from addresses near 0x0000 and near 0xFFFF, with garbage in the upper displacement byte. It then drives long displacements at the signed extremes from both ends of the address space.

The condition logic is covered by crossing all 16 codes with all 16 flag combinations. Every not-taken result in that sweep also confirms the fall-through address.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    COND_ALWAYS   = 4'd0,
    COND_NEVER    = 4'd1,
    COND_UHIGH    = 4'd2,
    COND_ULOWSAME = 4'd3,
    COND_CARRY0   = 4'd4,
    COND_CARRY1   = 4'd5,
    COND_NONZERO  = 4'd6,
    COND_ZERO     = 4'd7,
    COND_OVF0     = 4'd8,
    COND_OVF1     = 4'd9,
    COND_POS      = 4'd10,
    COND_NEG      = 4'd11,
    COND_SGE      = 4'd12,
    COND_SLT      = 4'd13,
    COND_SGT      = 4'd14,
    COND_SLE      = 4'd15
  } cond_code_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cpu_flags_t;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  cpu_flags_t  flg,
  input  logic [3:0]  sel,
  output logic        hit
);

  logic base;
  logic sgn_lt;

  assign sgn_lt = flg.n ^ flg.v;

  // Bits [3:1] pick a base test; bit 0 inverts it.
  always_comb begin
    unique case (sel[3:1])
      3'd0: base = 1'b1;
      3'd1: base = ~flg.c & ~flg.z;
      3'd2: base = ~flg.c;
      3'd3: base = ~flg.z;
      3'd4: base = ~flg.v;
      3'd5: base = ~flg.n;
      3'd6: base = ~sgn_lt;
      3'd7: base = ~flg.z & ~sgn_lt;
      default: base = 1'b0;
    endcase
  end

  assign hit = base ^ sel[0];

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int PC_W    = 16,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16
) (
  input  logic [PC_W-1:0]   base_pc,
  input  logic [LONG_W-1:0] disp,
  input  logic              long_sel,
  output logic [PC_W-1:0]   target
);

  localparam int SEXT_S = PC_W - SHORT_W;

  logic [PC_W-1:0] short_ext;
  logic [PC_W-1:0] long_ext;

  assign short_ext = {{SEXT_S{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  generate
    if (LONG_W < PC_W) begin : g_long_ext
      assign long_ext = {{(PC_W-LONG_W){disp[LONG_W-1]}}, disp};
    end else if (LONG_W == PC_W) begin : g_long_eq
      assign long_ext = disp;
    end else begin : g_long_trunc
      assign long_ext = disp[PC_W-1:0];
    end
  endgenerate

  // The adder wraps naturally at PC_W bits.
  assign target = base_pc + (long_sel ? long_ext : short_ext);

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16,
  parameter int COND_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        flags,
  input  logic [COND_W-1:0] cond_sel,
  input  logic              long_sel,
  input  logic [LONG_W-1:0] disp,
  input  logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [PC_W-1:0]   target_pc
);

  cpu_flags_t      flg;
  logic            hit;
  logic [PC_W-1:0] branch_pc;

  assign flg = cpu_flags_t'(flags);

  br_cond_eval u_cond (
    .flg (flg),
    .sel (cond_sel[3:0]),
    .hit (hit)
  );

  br_target_calc #(
    .PC_W    (PC_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W)
  ) u_tgt (
    .base_pc  (next_pc),
    .disp     (disp),
    .long_sel (long_sel),
    .target   (branch_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      target_pc <= '0;
    end else begin
      taken     <= hit;
      target_pc <= hit ? branch_pc : next_pc;
    end
  end

endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int PC_W    = 16,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16,
  parameter int COND_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        flags,
  input logic [COND_W-1:0] cond_sel,
  input logic              long_sel,
  input logic [LONG_W-1:0] disp,
  input logic [PC_W-1:0]   next_pc,
  input logic              taken,
  input logic [PC_W-1:0]   target_pc
);

  logic primed;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 0) |=> taken); // R3

  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 1) |=> !taken); // R3

  AST_EQUAL_ON_Z: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 7 && flags[2]) |=> taken); // R6

  AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (rst)
    (primed && !taken) |-> (target_pc == $past(next_pc))); // R10

  AST_SHORT_REACH: assert property (@(posedge clk) disable iff (rst)
    (primed && taken && !$past(long_sel)) |->
      (target_pc == PC_W'($past(next_pc) +
        {{(PC_W-SHORT_W){$past(disp[SHORT_W-1])}}, $past(disp[SHORT_W-1:0])}))); // R8

endmodule

bind branch_resolver br_resolver_chk #(
  .PC_W    (PC_W),
  .SHORT_W (SHORT_W),
  .LONG_W  (LONG_W),
  .COND_W  (COND_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flags     (flags),
  .cond_sel  (cond_sel),
  .long_sel  (long_sel),
  .disp      (disp),
  .next_pc   (next_pc),
  .taken     (taken),
  .target_pc (target_pc)
);

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  flags;
  logic [3:0]  cond_sel;
  logic        long_sel;
  logic [15:0] disp;
  logic [15:0] next_pc;
  logic        taken;
  logic [15:0] target_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .cond_sel  (cond_sel),
    .long_sel  (long_sel),
    .disp      (disp),
    .next_pc   (next_pc),
    .taken     (taken),
    .target_pc (target_pc)
  );

  // Expected decision from the requirement text; flags = {N,Z,V,C}.
  function automatic bit want_taken(input logic [3:0] code, input logic [3:0] f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (code)
      4'd0:  return 1;               // R3
      4'd1:  return 0;               // R3
      4'd2:  return (c == 0) && (z == 0);   // R4
      4'd3:  return (c == 1) || (z == 1);   // R4
      4'd4:  return c == 0;          // R5
      4'd5:  return c == 1;          // R5
      4'd6:  return z == 0;          // R6
      4'd7:  return z == 1;          // R6
      4'd8:  return v == 0;          // R6
      4'd9:  return v == 1;          // R6
      4'd10: return n == 0;          // R6
      4'd11: return n == 1;          // R6
      4'd12: return n == v;          // R7
      4'd13: return n != v;          // R7
      4'd14: return (z == 0) && (n == v);   // R7
      default: return (z == 1) || (n != v); // R7
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, sample one full cycle later (after one register).
  task automatic apply(input logic [3:0] code, input logic [3:0] f, input logic lg,
                       input logic [15:0] d, input logic [15:0] pc);
    @(negedge clk);
    cond_sel = code; flags = f; long_sel = lg; disp = d; next_pc = pc;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; flags = 4'hF; cond_sel = 4'd0; long_sel = 1'b1;
    disp = 16'h1234; next_pc = 16'hABCD;
    repeat (3) @(negedge clk);
    chk("R1 taken", {15'd0, taken}, 16'd0);
    chk("R1 pc", target_pc, 16'd0);
    rst = 1'b0;

    // R2: the outputs follow the inputs with exactly one register of delay.
    apply(4'd0, 4'h0, 1'b0, 16'h0010, 16'h2000);
    chk("R2 first", target_pc, 16'h2010);
    @(negedge clk);
    cond_sel = 4'd1; next_pc = 16'h3000;
    #1;
    chk("R2 held before edge", target_pc, 16'h2010);
    @(negedge clk);
    chk("R2 updated", target_pc, 16'h3000);

    // R3..R7, R10: all codes crossed with all flag patterns.
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        bit exp_t;
        logic [15:0] pc;
        pc = 16'(16'h4000 + code * 37 + f);
        exp_t = want_taken(4'(code), 4'(f));
        apply(4'(code), 4'(f), 1'b0, 16'h7F05, pc);
        chk($sformatf("R3-7 code%0d flags%h taken", code, f), {15'd0, taken}, {15'd0, exp_t});
        if (exp_t) chk("R8 cond target", target_pc, 16'(pc + 16'h0005));
        else       chk("R10 fallthrough", target_pc, pc);
      end
    end

    // R8: every short displacement, near both ends of the space, junk in the high byte.
    for (int d = 0; d < 256; d++) begin
      logic [15:0] sx;
      sx = {{8{d[7]}}, d[7:0]};
      apply(4'd0, 4'h0, 1'b0, {8'hA5, 8'(d)}, 16'h0003);
      chk("R8 short low", target_pc, 16'(16'h0003 + sx));
      apply(4'd0, 4'h0, 1'b0, {8'h5A, 8'(d)}, 16'hFFFC);
      chk("R8 short high", target_pc, 16'(16'hFFFC + sx));
    end

    // R9: long displacements at the extremes, with wrap in both directions.
    begin
      logic [15:0] dl [6] = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h1234, 16'hC000};
      logic [15:0] pl [3] = '{16'h0000, 16'hFFFF, 16'h8000};
      foreach (pl[i]) begin
        foreach (dl[j]) begin
          apply(4'd0, 4'h0, 1'b1, dl[j], pl[i]);
          chk("R9 long", target_pc, 16'(pl[i] + dl[j]));
        end
      end
    end

    // R10: a not-taken long branch ignores a large displacement.
    apply(4'd1, 4'hF, 1'b1, 16'h8000, 16'h1357);
    chk("R10 never long", target_pc, 16'h1357);

    // R1: reset in the middle of traffic clears the outputs.
    @(negedge clk);
    cond_sel = 4'd0; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid taken", {15'd0, taken}, 16'd0);
    chk("R1 mid pc", target_pc, 16'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule